// File: doc/BRIEF.md
# Calendar Clock-Watch Counter with BCD Year

This block keeps wall-clock time as a packed calendar word and keeps the year in a separate four-digit BCD register. The packed word holds the second, minute, hour, day of week, day of month and month. Each one-second strobe moves the whole calendar forward by one second. The strobe is honoured only while the count enable is high. Every carry from the second up to the century is resolved in the same clock cycle, so the calendar is never seen in a half-updated state. Month lengths follow the Gregorian calendar, including the century exception to the leap-year rule.

Software sets the calendar in two steps. It first writes the year through the year-load strobe, which only stages the value. It then writes the packed word through the word-load strobe, and that write applies the staged year and the new word on the same edge. Two match registers, one for the packed word and one for the year, drive a sticky alarm flag. The flag is raised when a one-second advance lands on a calendar value equal to both match registers.

The bus decoder, the interrupt mask and the register read multiplexer sit outside this block. They connect to the strobes and to the read-back outputs listed below.

Top module: `cwc_calendar_clock`

## Requirements
- R1: After a synchronous active-low reset, `now_word` reads 0x021E_0000 and `now_year` reads 0x2000. This is 2000-01-01 00:00:00 with day of week 7 (Saturday). `match_word`, `match_year` and `alarm` read zero.
- R2: In the packed word, bits [5:0] are seconds, [11:6] minutes, [16:12] hours, [19:17] day of week (1 = Sunday to 7 = Saturday), [24:20] day of month and [28:25] month (1 = January). Bits [31:29] read zero. A clock edge that samples `tick` and `count_en` both high adds one second. The new value is visible after that edge. With either input low the word and the year hold.
- R3: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the date.
- R4: The day of week advances on every midnight carry and wraps from 7 to 1.
- R5: April, June, September and November end after day 30. The other non-February months end after day 31. At the end of a month the day of month returns to 1 and the month advances. December wraps to January and carries into the year.
- R6: February ends after day 29 in a leap year and after day 28 otherwise. A year is a leap year when it is divisible by 4. A century year is a leap year only when it is divisible by 400, so 2000 is one and 2100 is not.
- R7: The year register holds the year within the century in BCD in bits [7:0] and the century in BCD in bits [15:8]. It increments in BCD with the digit carries, for example 0x2099 to 0x2100 and 0x1999 to 0x2000. It wraps from 0x9999 to 0x0000.
- R8: A `year_ld` pulse on its own leaves `now_year` unchanged. The next `word_ld` applies the staged year on the same edge as the new word. If both strobes arrive in the same cycle, the year comes straight from `year_ld_val`.
- R9: A `word_ld` writes `word_ld_val[28:0]` to the word and drops bits [31:29]. It takes priority over a `tick` sampled on the same edge.
- R10: After an advance whose result equals both match registers, `alarm` rises one clock later. It stays high until `alarm_clr`. A set wins over a clear in the same cycle. Loading a value that already equals the match registers does not raise `alarm`.
- R11: `alarm` stays low when the advanced word equals `match_word` but the year differs from `match_year`.
- R12: `mword_wr` writes bits [28:0] of `mword_val` to `match_word`. `myear_wr` writes `myear_val` to `match_year`. Both registers read back on their outputs after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_en | input | 1 | Calendar counting enable |
| tick | input | 1 | One-cycle strobe, once per second |
| year_ld | input | 1 | Stage a new year |
| year_ld_val | input | 16 | BCD year to stage |
| word_ld | input | 1 | Load packed word and commit staged year |
| word_ld_val | input | 32 | Packed calendar word to load |
| mword_wr | input | 1 | Write the word match register |
| mword_val | input | 32 | Word match value |
| myear_wr | input | 1 | Write the year match register |
| myear_val | input | 16 | BCD year match value |
| alarm_clr | input | 1 | Clear the alarm flag |
| now_word | output | 32 | Current packed calendar word |
| now_year | output | 16 | Current BCD year |
| match_word | output | 32 | Word match register |
| match_year | output | 16 | Year match register |
| alarm | output | 1 | Sticky alarm flag |

## Verification
The bench loads calendar values one second before each rollover boundary and applies a single tick. The boundaries are the minute carry, the ends of 30-day and 31-day months, February in 2023, 2024, 2000 and 2100, and the turns of 1999, 2099 and 9999. A wrong month-length table or leap rule would land on day 29, 30 or 31 when it should land on day 1, or the reverse. A wrong BCD carry would produce codes such as 0x209A or 0x2000 where 0x2100 is expected. The staged year load is checked with a year write left pending, which a design that applies it at once would expose. The alarm is probed cycle by cycle to catch a flag that is early, non-sticky, raised on a word-only match, or raised by a plain load.

// File: rtl/cwc_pkg.sv
// Package: shared packed-word layout and calendar helper functions.
// Assumes the year is four BCD digits with the century in the upper byte.
package cwc_pkg;

    typedef struct packed {
        logic [2:0] spare;
        logic [3:0] mon;
        logic [4:0] mday;
        logic [2:0] wday;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cwc_word_t;

    localparam int          WORD_W    = 32;
    localparam logic [31:0] USED_MASK = 32'h1FFF_FFFF;

    // Residue mod 4 of a two-digit BCD value: 10 = 2 (mod 4).
    function automatic logic [1:0] bcd_pair_mod4(input logic [7:0] p);
        logic [4:0] s;
        s = {p[7:4], 1'b0} + {1'b0, p[3:0]};
        return s[1:0];
    endfunction

    // Gregorian leap test on a BCD century/year pair.
    function automatic logic is_leap(input logic [15:0] y);
        if (y[7:0] == 8'h00)
            return bcd_pair_mod4(y[15:8]) == 2'd0;
        else
            return bcd_pair_mod4(y[7:0]) == 2'd0;
    endfunction

    // Last day of a month given its number and the leap flag.
    function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
        case (m)
            4'd2:                       return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:    return 5'd30;
            default:                    return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/cwc_tod.sv
// Time-of-day counter: seconds, minutes, hours.
// Assumes adv is a one-cycle advance request and ld overrides it.
// day_roll flags, combinationally, an advance that crosses midnight.
module cwc_tod (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       ld,
    input  logic [5:0] ld_sec,
    input  logic [5:0] ld_min,
    input  logic [4:0] ld_hour,
    output logic [5:0] sec,
    output logic [5:0] min,
    output logic [4:0] hour,
    output logic       day_roll
);

    logic sec_end;
    logic min_end;

    // Carry terms for the second and minute wraps.
    assign sec_end  = sec >= 6'd59;
    assign min_end  = sec_end && (min >= 6'd59);
    assign day_roll = adv && min_end && (hour >= 5'd23);

    // Load or advance the three fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec  <= '0;
            min  <= '0;
            hour <= '0;
        end else if (ld) begin
            sec  <= ld_sec;
            min  <= ld_min;
            hour <= ld_hour;
        end else if (adv) begin
            sec <= sec_end ? 6'd0 : sec + 6'd1;
            if (sec_end)
                min <= (min >= 6'd59) ? 6'd0 : min + 6'd1;
            if (min_end)
                hour <= (hour >= 5'd23) ? 5'd0 : hour + 5'd1;
        end
    end

    a_r2_tod_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !ld) |=> $stable({sec, min, hour}));

    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld && sec == 6'd59) |=> (sec == 6'd0));

endmodule

// File: rtl/cwc_date.sv
// Date counter: day of week, day of month, month.
// Assumes leap reflects the current year; the load overrides an advance.
// year_roll flags, combinationally, an advance past 31 December.
module cwc_date #(
    parameter logic [2:0] RST_WDAY = 3'd7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       day_adv,
    input  logic       ld,
    input  logic [2:0] ld_wday,
    input  logic [4:0] ld_mday,
    input  logic [3:0] ld_mon,
    input  logic       leap,
    output logic [2:0] wday,
    output logic [4:0] mday,
    output logic [3:0] mon,
    output logic       year_roll
);

    import cwc_pkg::*;

    logic [4:0] mlen;
    logic       month_end;
    logic       year_end;

    // Month boundary detection from the current month and leap flag.
    always_comb begin
        mlen      = month_len(mon, leap);
        month_end = mday >= mlen;
        year_end  = month_end && (mon >= 4'd12);
    end

    assign year_roll = day_adv && year_end;

    // Load or advance the date fields on a midnight carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wday <= RST_WDAY;
            mday <= 5'd1;
            mon  <= 4'd1;
        end else if (ld) begin
            wday <= ld_wday;
            mday <= ld_mday;
            mon  <= ld_mon;
        end else if (day_adv) begin
            wday <= (wday >= 3'd7) ? 3'd1 : wday + 3'd1;
            mday <= month_end ? 5'd1 : mday + 5'd1;
            if (month_end)
                mon <= year_end ? 4'd1 : mon + 4'd1;
        end
    end

    a_r4_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (day_adv && !ld && wday == 3'd7) |=> (wday == 3'd1));

    a_r6_leap_feb: assert property (@(posedge clk) disable iff (!rst_n)
        (day_adv && !ld && leap && mon == 4'd2 && mday == 5'd28) |=> (mday == 5'd29));

endmodule

// File: rtl/cwc_bcd_year.sv
// BCD year register: DIGITS decimal digits with a ripple digit carry.
// Assumes each stored digit is 0..9; a load overrides an increment.
module cwc_bcd_year #(
    parameter int                    DIGITS  = 4,
    parameter logic [4*DIGITS-1:0]   RST_VAL = 16'h2000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc,
    input  logic                  ld,
    input  logic [4*DIGITS-1:0]   ld_val,
    output logic [4*DIGITS-1:0]   year
);

    localparam int YW = 4 * DIGITS;

    logic [DIGITS:0] carry;
    logic [YW-1:0]   year_nxt;

    assign carry[0] = inc;

    // One incrementer per decimal digit, chained by the carry.
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] d;
        logic       top;
        assign d   = year[4*g +: 4];
        assign top = d >= 4'd9;
        assign year_nxt[4*g +: 4] = carry[g] ? (top ? 4'd0 : d + 4'd1) : d;
        assign carry[g+1] = carry[g] && top;
    end

    // Hold, load or take the incremented value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            year <= RST_VAL;
        else if (ld)
            year <= ld_val;
        else
            year <= year_nxt;
    end

    a_r8_year_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !ld) |=> $stable(year));

    a_r7_low_digit: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld && year[3:0] < 4'd9) |=> (year[3:0] == $past(year[3:0]) + 4'd1));

endmodule

// File: rtl/cwc_alarm.sv
// Alarm: word and year match registers and the sticky alarm flag.
// Assumes adv marks the cycle whose edge advances the calendar; the
// comparison uses the advanced value, one cycle later.
module cwc_alarm #(
    parameter int YW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [31:0]   now_word,
    input  logic [YW-1:0] now_year,
    input  logic          mword_wr,
    input  logic [31:0]   mword_val,
    input  logic          myear_wr,
    input  logic [YW-1:0] myear_val,
    input  logic          clr,
    output logic [31:0]   match_word,
    output logic [YW-1:0] match_year,
    output logic          flag
);

    import cwc_pkg::*;

    logic adv_q;
    logic hit;

    assign hit = adv_q && (now_word == match_word) && (now_year == match_year);

    // Match register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_word <= '0;
            match_year <= '0;
        end else begin
            if (mword_wr) match_word <= mword_val & USED_MASK;
            if (myear_wr) match_year <= myear_val;
        end
    end

    // Delay the advance marker and keep the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adv_q <= 1'b0;
            flag  <= 1'b0;
        end else begin
            adv_q <= adv;
            flag  <= hit | (flag & ~clr);
        end
    end

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    a_r11_year_needed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(now_year) == $past(match_year)));

endmodule

// File: rtl/cwc_calendar_clock.sv
// Top: calendar counter with packed time word, staged BCD year load and
// match alarm. Assumes tick is a one-cycle strobe at 1 Hz and that the
// bus decoder outside drives the one-cycle load and write strobes.
module cwc_calendar_clock #(
    parameter int                    YEAR_DIGITS = 4,
    parameter logic [4*YEAR_DIGITS-1:0] RST_YEAR = 16'h2000,
    parameter logic [2:0]            RST_WDAY    = 3'd7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       count_en,
    input  logic                       tick,
    input  logic                       year_ld,
    input  logic [4*YEAR_DIGITS-1:0]   year_ld_val,
    input  logic                       word_ld,
    input  logic [31:0]                word_ld_val,
    input  logic                       mword_wr,
    input  logic [31:0]                mword_val,
    input  logic                       myear_wr,
    input  logic [4*YEAR_DIGITS-1:0]   myear_val,
    input  logic                       alarm_clr,
    output logic [31:0]                now_word,
    output logic [4*YEAR_DIGITS-1:0]   now_year,
    output logic [31:0]                match_word,
    output logic [4*YEAR_DIGITS-1:0]   match_year,
    output logic                       alarm
);

    import cwc_pkg::*;

    localparam int YW = 4 * YEAR_DIGITS;

    cwc_word_t     ld_w;
    cwc_word_t     cur_w;
    logic          adv;
    logic          day_roll;
    logic          year_roll;
    logic          leap;
    logic [YW-1:0] yr_stage_q;
    logic          yr_pend_q;
    logic          yr_commit;
    logic [YW-1:0] yr_commit_val;

    assign ld_w = cwc_word_t'(word_ld_val);
    assign adv  = count_en && tick && !word_ld;
    assign leap = is_leap(now_year[15:0]);

    // Year staging: hold a written year until the next word load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            yr_stage_q <= '0;
            yr_pend_q  <= 1'b0;
        end else if (word_ld) begin
            yr_pend_q  <= 1'b0;
        end else if (year_ld) begin
            yr_stage_q <= year_ld_val;
            yr_pend_q  <= 1'b1;
        end
    end

    assign yr_commit     = word_ld && (yr_pend_q || year_ld);
    assign yr_commit_val = year_ld ? year_ld_val : yr_stage_q;

    cwc_tod u_tod (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .ld       (word_ld),
        .ld_sec   (ld_w.sec),
        .ld_min   (ld_w.min),
        .ld_hour  (ld_w.hour),
        .sec      (cur_w.sec),
        .min      (cur_w.min),
        .hour     (cur_w.hour),
        .day_roll (day_roll)
    );

    cwc_date #(.RST_WDAY(RST_WDAY)) u_date (
        .clk       (clk),
        .rst_n     (rst_n),
        .day_adv   (day_roll),
        .ld        (word_ld),
        .ld_wday   (ld_w.wday),
        .ld_mday   (ld_w.mday),
        .ld_mon    (ld_w.mon),
        .leap      (leap),
        .wday      (cur_w.wday),
        .mday      (cur_w.mday),
        .mon       (cur_w.mon),
        .year_roll (year_roll)
    );

    assign cur_w.spare = 3'b000;
    assign now_word    = cur_w;

    cwc_bcd_year #(.DIGITS(YEAR_DIGITS), .RST_VAL(RST_YEAR)) u_year (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (year_roll),
        .ld     (yr_commit),
        .ld_val (yr_commit_val),
        .year   (now_year)
    );

    cwc_alarm #(.YW(YW)) u_alarm (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .now_word   (now_word),
        .now_year   (now_year),
        .mword_wr   (mword_wr),
        .mword_val  (mword_val),
        .myear_wr   (myear_wr),
        .myear_val  (myear_val),
        .clr        (alarm_clr),
        .match_word (match_word),
        .match_year (match_year),
        .flag       (alarm)
    );

    a_r9_word_load: assert property (@(posedge clk) disable iff (!rst_n)
        word_ld |=> (now_word == {3'b000, $past(word_ld_val[28:0])}));

    a_r8_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ld && year_ld) |=> (now_year == $past(year_ld_val)));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(count_en && tick) && !word_ld) |=> $stable(now_word));

endmodule

// File: tb/sim_cwc_calendar_clock.sv
module sim_cwc_calendar_clock;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        count_en = 1'b0;
    logic        tick = 1'b0;
    logic        year_ld = 1'b0;
    logic [15:0] year_ld_val = '0;
    logic        word_ld = 1'b0;
    logic [31:0] word_ld_val = '0;
    logic        mword_wr = 1'b0;
    logic [31:0] mword_val = '0;
    logic        myear_wr = 1'b0;
    logic [15:0] myear_val = '0;
    logic        alarm_clr = 1'b0;
    logic [31:0] now_word;
    logic [15:0] now_year;
    logic [31:0] match_word;
    logic [15:0] match_year;
    logic        alarm;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    cwc_calendar_clock u0 (.*);

    function automatic logic [31:0] pk(input int mon, input int mday, input int wday,
                                       input int h, input int m, input int s);
        return {3'b000, 4'(mon), 5'(mday), 3'(wday), 5'(h), 6'(m), 6'(s)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick1();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic load_dt(input logic [15:0] y, input logic [31:0] w);
        @(negedge clk) begin year_ld = 1'b1; year_ld_val = y; end
        @(negedge clk) begin year_ld = 1'b0; word_ld = 1'b1; word_ld_val = w; end
        @(negedge clk) word_ld = 1'b0;
    endtask

    task automatic roll(input string tag, input logic [15:0] y0, input logic [31:0] w0,
                        input logic [15:0] y1, input logic [31:0] w1);
        load_dt(y0, w0);
        tick1();
        chk({tag, " word"}, now_word, w1);
        chk({tag, " year"}, {16'h0, now_year}, {16'h0, y1});
    endtask

    task automatic t_reset();
        chk("R1 word", now_word, 32'h021E_0000);
        chk("R1 year", {16'h0, now_year}, 32'h2000);
        chk("R1 match word", match_word, 32'h0);
        chk("R1 match year", {16'h0, match_year}, 32'h0);
        chk("R1 alarm", {31'h0, alarm}, 32'h0);
    endtask

    task automatic t_count();
        count_en = 1'b1;
        tick1(); tick1(); tick1();
        chk("R2 three ticks", now_word, 32'h021E_0003);
        count_en = 1'b0;
        tick1();
        chk("R2 disabled", now_word, 32'h021E_0003);
        count_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 no tick", now_word, 32'h021E_0003);
    endtask

    task automatic t_rollovers();
        roll("R3 minute carry", 16'h2031, pk(6,15,1,10,14,59), 16'h2031, pk(6,15,1,10,15,0));
        roll("R3 midnight", 16'h2031, pk(6,15,1,23,59,59), 16'h2031, pk(6,16,2,0,0,0));
        roll("R5 30-day", 16'h2031, pk(4,30,5,23,59,59), 16'h2031, pk(5,1,6,0,0,0));
        roll("R5 31-day", 16'h2031, pk(1,31,6,23,59,59), 16'h2031, pk(2,1,7,0,0,0));
        roll("R5 31-day jul", 16'h2031, pk(7,31,3,23,59,59), 16'h2031, pk(8,1,4,0,0,0));
        roll("R6 leap 2024", 16'h2024, pk(2,28,4,23,59,59), 16'h2024, pk(2,29,5,0,0,0));
        roll("R6 plain 2023", 16'h2023, pk(2,28,3,23,59,59), 16'h2023, pk(3,1,4,0,0,0));
        roll("R6 century 2100", 16'h2100, pk(2,28,1,23,59,59), 16'h2100, pk(3,1,2,0,0,0));
        roll("R6 quad century 2000", 16'h2000, pk(2,28,2,23,59,59), 16'h2000, pk(2,29,3,0,0,0));
        roll("R4 R7 2099", 16'h2099, pk(12,31,7,23,59,59), 16'h2100, pk(1,1,1,0,0,0));
        roll("R7 1999", 16'h1999, pk(12,31,6,23,59,59), 16'h2000, pk(1,1,7,0,0,0));
        roll("R7 9999", 16'h9999, pk(12,31,3,23,59,59), 16'h0000, pk(1,1,4,0,0,0));
    endtask

    task automatic t_year_stage();
        load_dt(16'h2031, pk(3,3,3,3,3,3));
        @(negedge clk) begin year_ld = 1'b1; year_ld_val = 16'h1234; end
        @(negedge clk) year_ld = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 staged only", {16'h0, now_year}, 32'h2031);
        @(negedge clk) begin word_ld = 1'b1; word_ld_val = pk(9,9,2,9,9,9); end
        @(negedge clk) word_ld = 1'b0;
        chk("R8 commit year", {16'h0, now_year}, 32'h1234);
        chk("R8 commit word", now_word, pk(9,9,2,9,9,9));
        @(negedge clk) begin year_ld = 1'b1; year_ld_val = 16'h0777;
                             word_ld = 1'b1; word_ld_val = pk(5,5,5,5,5,5); end
        @(negedge clk) begin year_ld = 1'b0; word_ld = 1'b0; end
        chk("R8 same cycle", {16'h0, now_year}, 32'h0777);
    endtask

    task automatic t_load_prio();
        @(negedge clk) begin tick = 1'b1; word_ld = 1'b1;
                             word_ld_val = pk(8,20,4,12,0,0) | 32'hE000_0000; end
        @(negedge clk) begin tick = 1'b0; word_ld = 1'b0; end
        chk("R9 load wins, spare dropped", now_word, pk(8,20,4,12,0,0));
    endtask

    task automatic t_alarm();
        @(negedge clk) begin mword_wr = 1'b1; mword_val = pk(3,15,1,8,30,0) | 32'hE000_0000;
                             myear_wr = 1'b1; myear_val = 16'h2031; end
        @(negedge clk) begin mword_wr = 1'b0; myear_wr = 1'b0; end
        chk("R12 match word", match_word, pk(3,15,1,8,30,0));
        chk("R12 match year", {16'h0, match_year}, 32'h2031);
        load_dt(16'h2031, pk(3,15,1,8,29,59));
        tick1();
        chk("R10 not yet", {31'h0, alarm}, 32'h0);
        @(negedge clk);
        chk("R10 raised", {31'h0, alarm}, 32'h1);
        repeat (3) @(negedge clk);
        chk("R10 sticky", {31'h0, alarm}, 32'h1);
        @(negedge clk) alarm_clr = 1'b1;
        @(negedge clk) alarm_clr = 1'b0;
        chk("R10 cleared", {31'h0, alarm}, 32'h0);
        load_dt(16'h2031, pk(3,15,1,8,30,0));
        repeat (2) @(negedge clk);
        chk("R10 load no alarm", {31'h0, alarm}, 32'h0);
        @(negedge clk) begin myear_wr = 1'b1; myear_val = 16'h2032; end
        @(negedge clk) myear_wr = 1'b0;
        load_dt(16'h2031, pk(3,15,1,8,29,59));
        tick1();
        @(negedge clk);
        chk("R11 year mismatch", {31'h0, alarm}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_rollovers();
        t_year_stage();
        t_load_prio();
        t_alarm();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule